// File: doc/BRIEF.md
# SPI Command Transaction Sequencer

This block carries out one complete SPI transaction from a single 32-bit command word. When a command is written, it selects one peripheral and holds that select low until the last byte has been shifted. For each byte it starts the external byte shifter and waits for the shifter to report completion. It takes outgoing bytes from the transmit FIFO and passes incoming bytes on to the receive FIFO.

A skip count splits the transaction into two phases. The first phase is write-only: its bytes come from the transmit FIFO, and the bytes received during it are thrown away. The second phase is read-only: it shifts zero bytes without touching the transmit FIFO, stores every byte it receives, and can ask the shifter to use two data lines. A transmit-only flag stops all receive storage. If transmit data is needed and the FIFO is empty, the sequencer waits with the select still asserted. When the last byte completes, the sequencer emits a one-cycle done pulse and releases the select.

Top module: `spi_cmd_seq`

## Requirements
- R1: While a transaction is active, exactly one select line is low: `cs_n[cmd_word[31:30]]`. While idle, all select lines are high.
- R2: The field `cmd_word[15:0]` holds the byte count minus one. A transaction issues exactly that count plus one shifter requests (`sh_req` pulses), one at a time. Each request waits for `sh_ack` before the next is issued.
- R3: The skip count is `cmd_word[23:16]`. The bytes received for the first skip-count requests are not pushed. Every later received byte is pushed with its `sh_rxd` value, in order. The number of pushes is the byte count minus the skip count, or zero if the skip count is not smaller.
- R4: With a skip count of zero, every byte pops the transmit FIFO (`tx_pop`) and is sent as the FIFO head (`sh_txd`).
- R5: With a nonzero skip count, the bytes before the skip count pop the FIFO and send its head. Every later byte is sent as 0x00 without a pop.
- R6: When `cmd_word[27]` (transmit-only) is set, no received byte is pushed.
- R7: `cmd_word[28]` (dual) raises `sh_dual` with each request whose byte index is at or beyond a nonzero skip count. When the skip count is zero, the dual flag is ignored and `sh_dual` stays low.
- R8: When a byte needs transmit data and `tx_empty` is high, no request is issued, and the select stays asserted until data arrives.
- R9: A command written while a transaction is active is ignored. The running transaction continues unchanged.
- R10: `done` is a single-cycle pulse in the same cycle that the select lines return high. It follows the final acknowledge.
- R11: After reset, all select lines are high, and `sh_req`, `tx_pop`, `rx_push` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Pop one byte from the transmit FIFO |
| sh_req | output | 1 | Start one byte on the shifter |
| sh_txd | output | 8 | Byte to shift out |
| sh_dual | output | 1 | Shift this byte on two data lines |
| sh_ack | input | 1 | Shifter finished the byte |
| sh_rxd | input | 8 | Byte received by the shifter |
| rx_push | output | 1 | Push one byte into the receive FIFO |
| rx_data | output | 8 | Byte to push |
| cs_n | output | NCS | Active-low chip selects |
| done | output | 1 | Transaction complete pulse |

## Verification
The sequencer is tested with the following command patterns:
- A plain full-duplex command and a one-byte command. These separate correct length counting from an off-by-one error.
- A skip command with dual set, which shows the phase boundary in pops, zero data, dual flags and which bytes are pushed.
- A skip count equal to or above the length, and a dual request with no skip. These expose missing clamps and missing gating.
- Transmit-only, a starved FIFO, and a second command written during a transfer. These cover suppressed storage, stall with the select held, and the busy lockout.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CMD_W     = 32;
  localparam int LEN_LSB   = 0;
  localparam int LEN_W     = 16;
  localparam int SKIP_LSB  = 16;
  localparam int SKIP_W    = 8;
  localparam int TXONLY_B  = 27;
  localparam int DUAL_B    = 28;
  localparam int CSEL_LSB  = 30;
  localparam int CSEL_W    = 2;
  localparam int BYTE_W    = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [CSEL_W-1:0] csel;
    logic              dual;
    logic              txonly;
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  len_m1;
  } seq_cmd_t;

  function automatic seq_cmd_t decode_cmd(input logic [CMD_W-1:0] w);
    seq_cmd_t c;
    c.csel   = w[CSEL_LSB +: CSEL_W];
    c.skip   = w[SKIP_LSB +: SKIP_W];
    c.len_m1 = w[LEN_LSB +: LEN_W];
    c.txonly = w[TXONLY_B];
    c.dual   = w[DUAL_B] && (w[SKIP_LSB +: SKIP_W] != '0);
    return c;
  endfunction
endpackage

// File: rtl/spi_seq_byte_ctr.sv
module spi_seq_byte_ctr #(
  parameter int LEN_W  = 16,
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [SKIP_W-1:0] skip,
  output logic              last,
  output logic              in_skip
);
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] skip_ext;

  assign skip_ext = LEN_W'(skip);

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (inc) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (clr || inc) idx_q <= idx_d;
  end

  assign last    = (idx_q == len_m1);
  assign in_skip = (idx_q < skip_ext);

  // R2
  ctr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (idx_q != '0));
endmodule

// File: rtl/spi_seq_cs_dec.sv
module spi_seq_cs_dec #(
  parameter int NCS = 4,
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NCS-1:0]   cs_n
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = !(en && (sel == SEL_W'(g)));
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              sh_req,
  output logic [BYTE_W-1:0] sh_txd,
  output logic              sh_dual,
  input  logic              sh_ack,
  input  logic [BYTE_W-1:0] sh_rxd,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic [NCS-1:0]    cs_n,
  output logic              done
);
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1;

  seq_state_e        state_q, state_d;
  seq_cmd_t          cmd_q, cmd_in;
  logic              capture;
  logic              cnt_inc, last, in_skip, need_tx;
  logic              sh_req_d, sh_dual_d, tx_pop_d, rx_push_d, done_d;
  logic [BYTE_W-1:0] sh_txd_d;
  logic              sh_req_q, sh_dual_q, tx_pop_q, rx_push_q, done_q;
  logic [BYTE_W-1:0] sh_txd_q, rx_data_q;

  assign cmd_in  = decode_cmd(cmd_word);
  assign need_tx = in_skip || (cmd_q.skip == '0);

  spi_seq_byte_ctr #(.LEN_W(LEN_W), .SKIP_W(SKIP_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (capture),
    .inc     (cnt_inc),
    .len_m1  (cmd_q.len_m1),
    .skip    (cmd_q.skip),
    .last    (last),
    .in_skip (in_skip)
  );

  spi_seq_cs_dec #(.NCS(NCS)) u_cs (
    .en   (state_q != ST_IDLE),
    .sel  (SEL_W'(cmd_q.csel)),
    .cs_n (cs_n)
  );

  always_comb begin
    state_d   = state_q;
    capture   = 1'b0;
    cnt_inc   = 1'b0;
    sh_req_d  = 1'b0;
    sh_txd_d  = '0;
    sh_dual_d = 1'b0;
    tx_pop_d  = 1'b0;
    rx_push_d = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          capture = 1'b1;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!need_tx || !tx_empty) begin
          sh_req_d  = 1'b1;
          sh_txd_d  = need_tx ? tx_data : '0;
          tx_pop_d  = need_tx;
          sh_dual_d = cmd_q.dual && !in_skip;
          state_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (sh_ack) begin
          rx_push_d = !cmd_q.txonly && !in_skip;
          cnt_inc   = !last;
          done_d    = last;
          state_d   = last ? ST_IDLE : ST_ISSUE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sh_req_q  <= 1'b0;
      sh_txd_q  <= '0;
      sh_dual_q <= 1'b0;
      tx_pop_q  <= 1'b0;
      rx_push_q <= 1'b0;
      rx_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sh_req_q  <= sh_req_d;
      sh_txd_q  <= sh_txd_d;
      sh_dual_q <= sh_dual_d;
      tx_pop_q  <= tx_pop_d;
      rx_push_q <= rx_push_d;
      done_q    <= done_d;
      if (sh_ack) rx_data_q <= sh_rxd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd_q <= '0;
    else if (capture) cmd_q <= cmd_in;
  end

  assign tx_pop  = tx_pop_q;
  assign sh_req  = sh_req_q;
  assign sh_txd  = sh_txd_q;
  assign sh_dual = sh_dual_q;
  assign rx_push = rx_push_q;
  assign rx_data = rx_data_q;
  assign done    = done_q;

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&cs_n));
  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISSUE && need_tx && tx_empty) |=> !sh_req);
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && cmd_wr) |=> $stable(cmd_q));
endmodule

// File: tb/spi_cmd_seq_test.sv
module spi_cmd_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr;
  logic [31:0] cmd_word;
  logic       tx_empty;
  logic [7:0] tx_data;
  logic       tx_pop, sh_req, sh_dual, sh_ack, rx_push, done;
  logic [7:0] sh_txd, sh_rxd, rx_data;
  logic [3:0] cs_n;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] fifo [0:31];
  int wr_p = 0, rd_p = 0;
  int n_req, n_pop, n_push, n_ack, n_done, done_bad, pend;
  logic [7:0] txd_log [0:31];
  logic       dual_log [0:31];
  logic [7:0] rxi_log [0:31];
  logic [7:0] push_log [0:31];
  logic [3:0] cs_seen;
  logic       prev_done;

  always #2.5 clk = ~clk;

  assign tx_empty = (wr_p == rd_p);
  assign tx_data  = fifo[rd_p % 32];

  spi_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .sh_req(sh_req), .sh_txd(sh_txd), .sh_dual(sh_dual),
    .sh_ack(sh_ack), .sh_rxd(sh_rxd), .rx_push(rx_push),
    .rx_data(rx_data), .cs_n(cs_n), .done(done)
  );

  // shifter and FIFO model, acting between active edges
  always @(negedge clk) begin
    sh_ack <= 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        sh_ack <= 1'b1;
        sh_rxd <= 8'h3C ^ 8'(n_ack * 7);
        rxi_log[n_ack % 32] = 8'h3C ^ 8'(n_ack * 7);
        n_ack++;
      end
    end
    if (sh_req) begin
      txd_log[n_req % 32]  = sh_txd;
      dual_log[n_req % 32] = sh_dual;
      n_req++;
      pend = 2;
    end
    if (tx_pop) begin rd_p = rd_p + 1; n_pop++; end
    if (rx_push) begin push_log[n_push % 32] = rx_data; n_push++; end
    if (done) begin
      n_done++;
      if (cs_n != 4'hF || prev_done) done_bad++;
    end
    prev_done = done;
    cs_seen = cs_seen | ~cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    n_req = 0; n_pop = 0; n_push = 0; n_ack = 0; n_done = 0;
    done_bad = 0; cs_seen = 4'h0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    fifo[wr_p % 32] = b;
    wr_p = wr_p + 1;
  endtask

  task automatic send_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_word = w; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (n_done == 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input int sel, input bit dual, input bit txo,
                                     input int skip, input int len);
    return (32'(sel) << 30) | (32'(dual) << 28) | (32'(txo) << 27) |
           (32'(skip & 8'hFF) << 16) | 32'(len - 1);
  endfunction

  task automatic t_plain();
    clear_log();
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33); push_tx(8'h44);
    send_cmd(mk(2, 0, 0, 0, 4));
    wait_done();
    chk(n_req == 4, "R2 request count", n_req, 4);
    chk(n_pop == 4, "R4 pop count", n_pop, 4);
    chk(txd_log[0] == 8'h11 && txd_log[3] == 8'h44, "R4 tx bytes", txd_log[3], 8'h44);
    chk(n_push == 4, "R3 push count no skip", n_push, 4);
    chk(push_log[0] == rxi_log[0] && push_log[3] == rxi_log[3], "R3 rx data", push_log[3], rxi_log[3]);
    chk(cs_seen == 4'b0100, "R1 select line", cs_seen, 4);
    chk(n_done == 1 && done_bad == 0, "R10 done pulse", done_bad, 0);
  endtask

  task automatic t_skip_dual();
    clear_log();
    push_tx(8'hA1); push_tx(8'hA2);
    send_cmd(mk(1, 1, 0, 2, 6));
    wait_done();
    chk(n_req == 6, "R2 request count skip", n_req, 6);
    chk(n_pop == 2, "R5 pop count", n_pop, 2);
    chk(txd_log[1] == 8'hA2 && txd_log[2] == 8'h00 && txd_log[5] == 8'h00, "R5 zero fill", txd_log[2], 0);
    chk(dual_log[1] == 1'b0 && dual_log[2] == 1'b1 && dual_log[5] == 1'b1, "R7 dual phase", dual_log[2], 1);
    chk(n_push == 4, "R3 push count", n_push, 4);
    chk(push_log[0] == rxi_log[2] && push_log[3] == rxi_log[5], "R3 skipped data", push_log[0], rxi_log[2]);
    chk(cs_seen == 4'b0010, "R1 select line 1", cs_seen, 2);
  endtask

  task automatic t_skip_ge_len();
    clear_log();
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    send_cmd(mk(0, 0, 0, 5, 3));
    wait_done();
    chk(n_push == 0, "R3 skip beyond length", n_push, 0);
    chk(n_pop == 3 && n_done == 1, "R5 all bytes from fifo", n_pop, 3);
  endtask

  task automatic t_txonly();
    clear_log();
    push_tx(8'h5A); push_tx(8'h6B); push_tx(8'h7C);
    send_cmd(mk(3, 0, 1, 0, 3));
    wait_done();
    chk(n_push == 0, "R6 transmit only", n_push, 0);
    chk(n_req == 3 && n_pop == 3, "R6 bytes sent", n_req, 3);
  endtask

  task automatic t_dual_noskip();
    clear_log();
    push_tx(8'hC1); push_tx(8'hC2);
    send_cmd(mk(0, 1, 0, 0, 2));
    wait_done();
    chk(dual_log[0] == 1'b0 && dual_log[1] == 1'b0, "R7 dual ignored", dual_log[1], 0);
    chk(n_push == 2, "R7 full duplex kept", n_push, 2);
  endtask

  task automatic t_one_byte();
    clear_log();
    push_tx(8'hEE);
    send_cmd(mk(1, 0, 0, 0, 1));
    wait_done();
    chk(n_req == 1 && n_done == 1, "R2 single byte", n_req, 1);
  endtask

  task automatic t_stall();
    clear_log();
    push_tx(8'h91);
    send_cmd(mk(2, 0, 0, 0, 3));
    repeat (30) @(negedge clk);
    chk(n_req == 1, "R8 stalled requests", n_req, 1);
    chk(cs_n == 4'b1011 && n_done == 0, "R8 select held", cs_n, 11);
    push_tx(8'h92); push_tx(8'h93);
    wait_done();
    chk(n_req == 3 && txd_log[2] == 8'h93, "R8 resume", txd_log[2], 8'h93);
  endtask

  task automatic t_busy();
    clear_log();
    push_tx(8'h21); push_tx(8'h22);
    send_cmd(mk(1, 0, 0, 0, 2));
    send_cmd(mk(3, 0, 0, 0, 8));
    wait_done();
    repeat (20) @(negedge clk);
    chk(n_req == 2 && n_done == 1, "R9 busy command ignored", n_req, 2);
    chk(cs_seen == 4'b0010, "R9 no other select", cs_seen, 2);
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_word = '0;
    sh_ack = 1'b0; sh_rxd = '0; pend = 0; prev_done = 1'b0;
    clear_log();
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF, "R11 reset selects", cs_n, 15);
    chk(!sh_req && !tx_pop && !rx_push && !done, "R11 reset strobes", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_plain();
    t_skip_dual();
    t_skip_ge_len();
    t_txonly();
    t_dual_noskip();
    t_one_byte();
    t_stall();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule